// File: doc/BRIEF.md
# Bridge Data Parity Error Status Tracker

This block keeps the data parity error status for a two-port bus bridge. Each error event arrives as a single-cycle strobe with three fields: the kind of transaction (read, posted write or delayed write), which way it was travelling (downstream or upstream), and which bus saw the bad parity (primary or secondary). From these fields the block decides whether to set the sticky primary-side bit, the sticky secondary-side bit, or neither.

In the same event, the block decides whether to pull the active-low primary system-error output low for one clock. It does so only when three enables from the configuration registers are all set and the error was not forwarded onto the target bus. Software clears either status bit by writing a 1 to its position. Bus protocol sequencing, parity generation and data movement are handled elsewhere.

Top module: `perr_status_top`

## Requirements
- R1: On an event with err_valid high, pri_det_perr is set one clock later for these three cases. Read (err_type 2'b00), upstream (err_dir 1), seen on primary (err_bus 0). Posted write (2'b01), downstream (err_dir 0), seen on primary. Delayed write (2'b10), downstream, seen on primary.
- R2: On an event, sec_det_perr is set one clock later for two cases. Read, downstream, seen on secondary (err_bus 1). Posted write, upstream, seen on secondary.
- R3: Every other combination of type, direction and bus leaves both status bits unchanged. This includes the unused type code 2'b11.
- R4: Whether a status bit is set does not depend on cmd_perr_resp or bctl_perr_resp.
- R5: Status bits are sticky. A cycle with sw_wr high and a 1 in sw_wdata clears the matching bit on the next clock: bit 0 clears pri_det_perr and bit 1 clears sec_det_perr. A 0 in a bit position has no effect.
- R6: If a set and a write-1 clear hit the same bit in the same cycle, the bit ends up set.
- R7: serr_n is low for exactly the one clock after an event that meets all of these conditions: cmd_serr_en, cmd_perr_resp and bctl_perr_resp are all 1, and err_fwd is 0. The output is registered.
- R8: serr_n stays high for an event that has err_fwd at 1, or that has any of the three enables at 0.
- R9: While rst is high, and on the clock after it, both status bits are 0 and serr_n is 1.
- R10: When err_valid is low, the error fields and err_fwd have no effect on either status bit or on serr_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_valid | input | 1 | Single-cycle parity error event strobe |
| err_type | input | 2 | 00 read, 01 posted write, 10 delayed write |
| err_dir | input | 1 | 0 downstream, 1 upstream |
| err_bus | input | 1 | 0 primary bus, 1 secondary bus |
| err_fwd | input | 1 | Error was forwarded to the target bus |
| cmd_serr_en | input | 1 | System-error enable from the command register |
| cmd_perr_resp | input | 1 | Primary parity error response enable |
| bctl_perr_resp | input | 1 | Secondary parity error response enable (bridge control) |
| sw_wr | input | 1 | Status write strobe |
| sw_wdata | input | 2 | Write-1-to-clear data: bit 0 primary, bit 1 secondary |
| pri_det_perr | output | 1 | Primary detected parity error status |
| sec_det_perr | output | 1 | Secondary detected parity error status |
| serr_n | output | 1 | Active-low system-error pulse |

## Verification
The bench sweeps all twelve combinations of type, direction and bus, plus the unused type code. A decoder that keys only on the bus would set a bit for the wrong direction or type, and this sweep exposes it. It drives a set and a clear into the same cycle, where a clear-priority design would drop the event. It toggles each enable and the forwarded flag one at a time, where a design that ignores any one of them would pulse serr_n when it should not. It also checks that serr_n does not stretch past one clock, and that write-0 cycles and idle cycles with the error fields changing leave the status alone.

// File: rtl/perr_pkg.sv
package perr_pkg;
  localparam int TYPE_W = 2;
  localparam int NUM_STAT = 2;
  localparam int STAT_PRI = 0;
  localparam int STAT_SEC = 1;

  typedef enum logic [TYPE_W-1:0] {
    XFER_READ    = 2'b00,
    XFER_POSTED  = 2'b01,
    XFER_DELAYED = 2'b10,
    XFER_RSVD    = 2'b11
  } xfer_e;

  typedef enum logic { DIR_DOWN = 1'b0, DIR_UP = 1'b1 } dir_e;
  typedef enum logic { BUS_PRI = 1'b0, BUS_SEC = 1'b1 } bus_e;

  typedef struct packed {
    xfer_e kind;
    dir_e  dir;
    bus_e  bus;
  } perr_evt_t;
endpackage

// File: rtl/perr_classify.sv
module perr_classify
  import perr_pkg::*;
(
  input  logic                valid,
  input  perr_evt_t           evt,
  output logic [NUM_STAT-1:0] set_vec
);
  logic pri_hit;
  logic sec_hit;

  always_comb begin
    pri_hit = 1'b0;
    sec_hit = 1'b0;
    if (evt.bus == BUS_PRI) begin
      unique case (evt.kind)
        XFER_READ:    pri_hit = (evt.dir == DIR_UP);
        XFER_POSTED:  pri_hit = (evt.dir == DIR_DOWN);
        XFER_DELAYED: pri_hit = (evt.dir == DIR_DOWN);
        default:      pri_hit = 1'b0;
      endcase
    end else begin
      unique case (evt.kind)
        XFER_READ:    sec_hit = (evt.dir == DIR_DOWN);
        XFER_POSTED:  sec_hit = (evt.dir == DIR_UP);
        default:      sec_hit = 1'b0;
      endcase
    end
  end

  always_comb begin
    set_vec = '0;
    set_vec[STAT_PRI] = valid && pri_hit;
    set_vec[STAT_SEC] = valid && sec_hit;
  end

  // R3: never both bits from a single event
  always_comb begin
    a_r3_single_target: assert ($onehot0(set_vec));
  end
endmodule

// File: rtl/perr_sticky_bit.sv
module perr_sticky_bit (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= 1'b0;
    else if (set_i) q <= 1'b1;
    else if (clr_i) q <= 1'b0;
  end

  a_r1_set_lands: assert property (@(posedge clk) disable iff (rst)
    set_i |=> q);
  a_r5_sticky_hold: assert property (@(posedge clk) disable iff (rst)
    (q && !clr_i) |=> q);
  a_r5_clear_lands: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !q);
  a_r3_no_spurious_set: assert property (@(posedge clk) disable iff (rst)
    (!q && !set_i) |=> !q);
endmodule

// File: rtl/perr_serr_gen.sv
module perr_serr_gen (
  input  logic clk,
  input  logic rst,
  input  logic valid,
  input  logic fwd,
  input  logic serr_en,
  input  logic pri_resp,
  input  logic sec_resp,
  output logic serr_n
);
  logic fire;
  assign fire = valid && !fwd && serr_en && pri_resp && sec_resp;

  always_ff @(posedge clk) begin
    if (rst) serr_n <= 1'b1;
    else     serr_n <= !fire;
  end

  a_r8_fwd_blocks: assert property (@(posedge clk) disable iff (rst)
    (valid && fwd) |=> serr_n);
  a_r8_enable_gate: assert property (@(posedge clk) disable iff (rst)
    (!serr_en || !pri_resp || !sec_resp) |=> serr_n);
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !valid |=> serr_n);
endmodule

// File: rtl/perr_status_top.sv
module perr_status_top
  import perr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              err_valid,
  input  logic [TYPE_W-1:0] err_type,
  input  logic              err_dir,
  input  logic              err_bus,
  input  logic              err_fwd,
  input  logic              cmd_serr_en,
  input  logic              cmd_perr_resp,
  input  logic              bctl_perr_resp,
  input  logic              sw_wr,
  input  logic [NUM_STAT-1:0] sw_wdata,
  output logic              pri_det_perr,
  output logic              sec_det_perr,
  output logic              serr_n
);
  perr_evt_t            evt;
  logic [NUM_STAT-1:0]  set_vec;
  logic [NUM_STAT-1:0]  clr_vec;
  logic [NUM_STAT-1:0]  stat_q;

  assign evt.kind = xfer_e'(err_type);
  assign evt.dir  = dir_e'(err_dir);
  assign evt.bus  = bus_e'(err_bus);
  assign clr_vec  = sw_wr ? sw_wdata : '0;

  perr_classify u_classify (
    .valid   (err_valid),
    .evt     (evt),
    .set_vec (set_vec)
  );

  for (genvar i = 0; i < NUM_STAT; i++) begin : g_stat
    perr_sticky_bit u_bit (
      .clk   (clk),
      .rst   (rst),
      .set_i (set_vec[i]),
      .clr_i (clr_vec[i]),
      .q     (stat_q[i])
    );
  end

  perr_serr_gen u_serr (
    .clk      (clk),
    .rst      (rst),
    .valid    (err_valid),
    .fwd      (err_fwd),
    .serr_en  (cmd_serr_en),
    .pri_resp (cmd_perr_resp),
    .sec_resp (bctl_perr_resp),
    .serr_n   (serr_n)
  );

  assign pri_det_perr = stat_q[STAT_PRI];
  assign sec_det_perr = stat_q[STAT_SEC];

  a_r9_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (serr_n && !pri_det_perr && !sec_det_perr));
  a_r7_serr_cause: assert property (@(posedge clk) disable iff (rst)
    !serr_n |-> $past(err_valid && !err_fwd && cmd_serr_en && cmd_perr_resp && bctl_perr_resp));
  a_r6_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
    (sw_wr && sw_wdata[STAT_SEC] && err_valid && err_bus && !err_dir && err_type == 2'b00)
    |=> sec_det_perr);
endmodule

// File: tb/perr_status_top_tb.sv
module perr_status_top_tb;
  logic clk = 0;
  logic rst;
  logic err_valid, err_dir, err_bus, err_fwd;
  logic [1:0] err_type;
  logic cmd_serr_en, cmd_perr_resp, bctl_perr_resp;
  logic sw_wr;
  logic [1:0] sw_wdata;
  logic pri_det_perr, sec_det_perr, serr_n;
  int n_tests = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  perr_status_top u_dut (
    .clk(clk), .rst(rst), .err_valid(err_valid), .err_type(err_type),
    .err_dir(err_dir), .err_bus(err_bus), .err_fwd(err_fwd),
    .cmd_serr_en(cmd_serr_en), .cmd_perr_resp(cmd_perr_resp),
    .bctl_perr_resp(bctl_perr_resp), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
    .pri_det_perr(pri_det_perr), .sec_det_perr(sec_det_perr), .serr_n(serr_n)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle();
    err_valid = 0; err_type = 0; err_dir = 0; err_bus = 0; err_fwd = 0;
    sw_wr = 0; sw_wdata = 0;
  endtask

  // drive at negedge, let one posedge pass, return at next negedge
  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic event_cyc(input logic [1:0] t, input logic d, input logic b, input logic f);
    err_valid = 1; err_type = t; err_dir = d; err_bus = b; err_fwd = f;
    step();
    idle();
  endtask

  task automatic clear_all();
    sw_wr = 1; sw_wdata = 2'b11;
    step();
    idle();
  endtask

  task automatic set_en(input logic a, input logic b, input logic c);
    cmd_serr_en = a; cmd_perr_resp = b; bctl_perr_resp = c;
  endtask

  task automatic t_reset();
    rst = 1; idle(); set_en(1, 1, 1);
    err_valid = 1; err_type = 2'b00; err_dir = 1; err_bus = 0;
    step(); step();
    check("R9 pri in reset", pri_det_perr, 0);
    check("R9 sec in reset", sec_det_perr, 0);
    check("R9 serr_n in reset", serr_n, 1);
    idle(); rst = 0;
    step();
    check("R9 pri after reset", pri_det_perr, 0);
    check("R9 serr_n after reset", serr_n, 1);
  endtask

  task automatic t_decode_sweep();
    for (int t = 0; t < 4; t++)
      for (int d = 0; d < 2; d++)
        for (int b = 0; b < 2; b++) begin
          bit ep, es;
          ep = (b == 0) && ((t == 0 && d == 1) || (t == 1 && d == 0) || (t == 2 && d == 0));
          es = (b == 1) && ((t == 0 && d == 0) || (t == 1 && d == 1));
          clear_all();
          set_en(0, 0, 0);
          event_cyc(2'(t), 1'(d), 1'(b), 0);
          check($sformatf("R1/R3 pri t%0d d%0d b%0d", t, d, b), pri_det_perr, int'(ep));
          check($sformatf("R2/R3 sec t%0d d%0d b%0d", t, d, b), sec_det_perr, int'(es));
        end
  endtask

  task automatic t_resp_independent();
    for (int m = 0; m < 4; m++) begin
      clear_all();
      set_en(1, m[0], m[1]);
      event_cyc(2'b01, 0, 0, 0);
      check($sformatf("R4 pri set resp=%0d", m), pri_det_perr, 1);
      event_cyc(2'b01, 1, 1, 0);
      check($sformatf("R4 sec set resp=%0d", m), sec_det_perr, 1);
    end
  endtask

  task automatic t_sticky_clear();
    clear_all();
    event_cyc(2'b00, 1, 0, 0);
    event_cyc(2'b00, 0, 1, 0);
    repeat (3) step();
    check("R5 pri holds", pri_det_perr, 1);
    check("R5 sec holds", sec_det_perr, 1);
    sw_wr = 1; sw_wdata = 2'b00; step(); idle();
    check("R5 write0 pri", pri_det_perr, 1);
    check("R5 write0 sec", sec_det_perr, 1);
    sw_wr = 0; sw_wdata = 2'b11; step(); idle();
    check("R5 no strobe pri", pri_det_perr, 1);
    sw_wr = 1; sw_wdata = 2'b01; step(); idle();
    check("R5 w1c pri cleared", pri_det_perr, 0);
    check("R5 w1c sec kept", sec_det_perr, 1);
    sw_wr = 1; sw_wdata = 2'b10; step(); idle();
    check("R5 w1c sec cleared", sec_det_perr, 0);
  endtask

  task automatic t_set_vs_clear();
    clear_all();
    event_cyc(2'b10, 0, 0, 0);
    sw_wr = 1; sw_wdata = 2'b11;
    err_valid = 1; err_type = 2'b10; err_dir = 0; err_bus = 0;
    step(); idle();
    check("R6 pri set wins", pri_det_perr, 1);
    check("R6 sec cleared", sec_det_perr, 0);
  endtask

  task automatic t_serr_pulse();
    set_en(1, 1, 1);
    err_valid = 1; err_type = 2'b00; err_dir = 0; err_bus = 1; err_fwd = 0;
    step(); idle();
    check("R7 serr_n low", serr_n, 0);
    step();
    check("R7 serr_n one cycle", serr_n, 1);
    // back-to-back events give two low cycles
    err_valid = 1; err_fwd = 0; step();
    check("R7 b2b first", serr_n, 0);
    step(); idle();
    check("R7 b2b second", serr_n, 0);
    step();
    check("R7 b2b release", serr_n, 1);
  endtask

  task automatic t_serr_gate();
    for (int m = 0; m < 8; m++) begin
      set_en(m[0], m[1], m[2]);
      err_valid = 1; err_type = 2'b01; err_dir = 1; err_bus = 1; err_fwd = 0;
      step(); idle();
      check($sformatf("R8 enables=%0d", m), serr_n, (m == 7) ? 0 : 1);
      step();
    end
    set_en(1, 1, 1);
    event_cyc(2'b00, 0, 1, 1);
    check("R8 forwarded", serr_n, 1);
  endtask

  task automatic t_idle_ignored();
    clear_all();
    set_en(1, 1, 1);
    for (int k = 0; k < 16; k++) begin
      err_valid = 0; err_type = 2'(k); err_dir = k[2]; err_bus = k[3]; err_fwd = 0;
      step();
      check("R10 idle serr_n", serr_n, 1);
    end
    idle();
    check("R10 idle pri", pri_det_perr, 0);
    check("R10 idle sec", sec_det_perr, 0);
  endtask

  initial begin
    idle(); set_en(0, 0, 0); rst = 1;
    @(negedge clk);
    t_reset();
    t_decode_sweep();
    t_resp_independent();
    t_sticky_clear();
    t_set_vs_clear();
    t_serr_pulse();
    t_serr_gate();
    t_idle_ignored();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule